// File: doc/BRIEF.md
# Terminal Keyboard/Display Register Block

This block is a bus slave that gives a processor access to a character terminal through four 32-bit word registers. One pair of registers serves the keyboard side: a control word and the last received character. The other pair serves the display side: a control word and the character to send. Each control word reports a Ready flag in bit 0. Each control word also has a software-writable interrupt enable in bit 1.

On the keyboard side, a byte arrives together with a one-cycle valid strobe. The block holds that byte and raises receiver Ready until software reads the receive data word. On the display side, software writes a character while the transmitter is Ready. The block then presents the byte to the display with a valid level and holds it there until the display acknowledges it. A single level interrupt request is driven whenever an enabled Ready flag is set.

The bus port is synchronous. Read data is combinational and is valid in the cycle that the read strobe is high. The side effects of a read or a write take place at the closing clock edge of that cycle.

Top module: `termio_regs`

## Requirements
- R1: The registers sit at BASE+0x0 (receive control), BASE+0x4 (receive data), BASE+0x8 (transmit control) and BASE+0xC (transmit data), with BASE = 0xFFFF0000 by default. A read of any other address returns 0, and a write to any other address changes no register.
- R2: In each control word, bit 0 is Ready and cannot be written. Bit 1 is the interrupt enable and is set or cleared by a write to that control word. Bits 31..2 always read 0.
- R3: When kbdValid is high at a clock edge, kbdByte is stored and receiver Ready reads 1 from the next cycle on. A bus read of receive data clears receiver Ready at the edge that closes the read.
- R4: Receive data returns the stored byte in bits 7..0, and bits 31..8 read 0.
- R5: A byte that arrives while receiver Ready is 1 replaces the stored byte, and Ready stays 1.
- R6: A write to transmit data while transmitter Ready is 1 places bits 7..0 of the write data on dispByte. From the next cycle on, dispValid is 1 and transmitter Ready reads 0.
- R7: dispValid and dispByte hold until dispAck is high at a clock edge. After that edge, dispValid is 0 and transmitter Ready reads 1.
- R8: A write to transmit data while transmitter Ready is 0 is ignored: dispByte does not change.
- R9: irq is high exactly when (receiver Ready and receive enable) or (transmitter Ready and transmit enable).
- R10: After reset, receiver Ready is 0, transmitter Ready is 1, both enables are 0, dispValid is 0 and irq is 0.
- R11: When a receive data read and kbdValid fall in the same cycle, the read returns the old byte, the new byte is stored and receiver Ready stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 32 | Byte address of the access |
| busRd | input | 1 | Read strobe |
| busWr | input | 1 | Write strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid while busRd is high |
| kbdByte | input | 8 | Incoming keyboard character |
| kbdValid | input | 1 | One-cycle strobe qualifying kbdByte |
| dispByte | output | 8 | Character offered to the display |
| dispValid | output | 1 | High while a character awaits acknowledge |
| dispAck | input | 1 | Display accepts the offered character |
| irq | output | 1 | Level interrupt request |

## Verification
Receive traffic is tested in three ways: a single byte followed by a read, two bytes with no read between them, and a byte that arrives in the same cycle as a data read. These cases separate the read-clear action from the priority of a new arrival. Transmit traffic is tested with a plain send and acknowledge, and with a second write while the first byte is still pending. That second case shows whether the busy gate drops the write or lets it through. The interrupt line is checked under every mix of enable and Ready state. Unmapped addresses and writes to the Ready bits are tested to show that no state is touched.

// File: rtl/termio_pkg.sv
package termio_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXCTL,
    SEL_RXDAT,
    SEL_TXCTL,
    SEL_TXDAT
  } regSel_t;

  typedef struct packed {
    logic rxLoad;
    logic rxClear;
    logic rxCtlWr;
    logic txCtlWr;
    logic txSend;
    logic txDone;
  } strobes_t;
endpackage

// File: rtl/termio_ctrl.sv
module termio_ctrl
  import termio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              kbdValid,
  input  logic              dispAck,
  input  logic              txReady,
  output regSel_t           rdSel,
  output strobes_t          strb
);
  localparam int NUM_REGS = 4;
  localparam int STRIDE   = 4;

  regSel_t hitSel;
  logic [NUM_REGS-1:0] hit;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] REG_ADDR = BASE_ADDR + ADDR_W'(i * STRIDE);
    assign hit[i] = (busAddr == REG_ADDR);
  end

  always_comb begin
    hitSel = SEL_NONE;
    unique case (1'b1)
      hit[0]:  hitSel = SEL_RXCTL;
      hit[1]:  hitSel = SEL_RXDAT;
      hit[2]:  hitSel = SEL_TXCTL;
      hit[3]:  hitSel = SEL_TXDAT;
      default: hitSel = SEL_NONE;
    endcase
  end

  always_comb begin
    rdSel        = busRd ? hitSel : SEL_NONE;
    strb.rxLoad  = kbdValid;
    strb.rxClear = busRd && (hitSel == SEL_RXDAT);
    strb.rxCtlWr = busWr && (hitSel == SEL_RXCTL);
    strb.txCtlWr = busWr && (hitSel == SEL_TXCTL);
    strb.txSend  = busWr && (hitSel == SEL_TXDAT) && txReady;
    strb.txDone  = dispAck && !txReady;
  end
endmodule

// File: rtl/termio_dp.sv
module termio_dp
  import termio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  regSel_t           rdSel,
  input  logic [DATA_W-1:0] busWdata,
  input  logic [CHAR_W-1:0] kbdByte,
  output logic [DATA_W-1:0] busRdata,
  output logic [CHAR_W-1:0] dispByte,
  output logic              txReady,
  output logic              irq
);
  localparam int READY_BIT = 0;
  localparam int IE_BIT    = 1;
  localparam int PAD_W     = DATA_W - CHAR_W;

  logic              rxReady;
  logic              rxIe;
  logic              txIe;
  logic [CHAR_W-1:0] rxByte;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReady <= 1'b0;
      rxByte  <= '0;
    end else if (strb.rxLoad) begin
      rxReady <= 1'b1;
      rxByte  <= kbdByte;
    end else if (strb.rxClear) begin
      rxReady <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxIe <= 1'b0;
      txIe <= 1'b0;
    end else begin
      if (strb.rxCtlWr) rxIe <= busWdata[IE_BIT];
      if (strb.txCtlWr) txIe <= busWdata[IE_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txReady  <= 1'b1;
      dispByte <= '0;
    end else if (strb.txSend) begin
      txReady  <= 1'b0;
      dispByte <= busWdata[CHAR_W-1:0];
    end else if (strb.txDone) begin
      txReady  <= 1'b1;
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (rdSel)
      SEL_RXCTL: begin
        busRdata[READY_BIT] = rxReady;
        busRdata[IE_BIT]    = rxIe;
      end
      SEL_RXDAT: busRdata = {{PAD_W{1'b0}}, rxByte};
      SEL_TXCTL: begin
        busRdata[READY_BIT] = txReady;
        busRdata[IE_BIT]    = txIe;
      end
      default: busRdata = '0;
    endcase
  end

  assign irq = (rxReady && rxIe) || (txReady && txIe);
endmodule

// File: rtl/termio_regs.sv
module termio_regs
  import termio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd,
  input  logic              busWr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CHAR_W-1:0] kbdByte,
  input  logic              kbdValid,
  output logic [CHAR_W-1:0] dispByte,
  output logic              dispValid,
  input  logic              dispAck,
  output logic              irq
);
  regSel_t  rdSel;
  strobes_t strb;
  logic     txReady;

  termio_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .busAddr (busAddr),
    .busRd   (busRd),
    .busWr   (busWr),
    .kbdValid(kbdValid),
    .dispAck (dispAck),
    .txReady (txReady),
    .rdSel   (rdSel),
    .strb    (strb)
  );

  termio_dp #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdSel   (rdSel),
    .busWdata(busWdata),
    .kbdByte (kbdByte),
    .busRdata(busRdata),
    .dispByte(dispByte),
    .txReady (txReady),
    .irq     (irq)
  );

  assign dispValid = !txReady;
endmodule

// File: rtl/termio_regs_chk.sv
module termio_regs_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CHAR_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hFFFF_0000
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busRd,
  input logic              busWr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic [CHAR_W-1:0] dispByte,
  input logic              dispValid,
  input logic              dispAck
);
  localparam logic [ADDR_W-1:0] A_RXCTL = BASE_ADDR;
  localparam logic [ADDR_W-1:0] A_RXDAT = BASE_ADDR + ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TXCTL = BASE_ADDR + ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_TXDAT = BASE_ADDR + ADDR_W'(12);

  logic ctlRead, datRead, txWrite;
  assign ctlRead = busRd && (busAddr == A_RXCTL || busAddr == A_TXCTL);
  assign datRead = busRd && (busAddr == A_RXDAT);
  assign txWrite = busWr && (busAddr == A_TXDAT);

  a_r2_ctl_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    ctlRead |-> (busRdata[DATA_W-1:2] == '0));

  a_r4_dat_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    datRead |-> (busRdata[DATA_W-1:CHAR_W] == '0));

  a_r6_send_presents: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && !dispValid) |=> (dispValid && dispByte == $past(busWdata[CHAR_W-1:0])));

  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && !dispAck) |=> (dispValid && $stable(dispByte)));

  a_r7_ack_releases: assert property (@(posedge clk) disable iff (!rstN)
    (dispValid && dispAck) |=> !dispValid);

  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (txWrite && dispValid) |=> $stable(dispByte));
endmodule

bind termio_regs termio_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busRd    (busRd),
  .busWr    (busWr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .dispByte (dispByte),
  .dispValid(dispValid),
  .dispAck  (dispAck)
);

// File: tb/termio_regs_bench.sv
module termio_regs_bench;
  localparam logic [31:0] A_RXCTL = 32'hFFFF_0000;
  localparam logic [31:0] A_RXDAT = 32'hFFFF_0004;
  localparam logic [31:0] A_TXCTL = 32'hFFFF_0008;
  localparam logic [31:0] A_TXDAT = 32'hFFFF_000C;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] busAddr = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [7:0]  kbdByte = '0;
  logic        kbdValid = 1'b0;
  logic [7:0]  dispByte;
  logic        dispValid;
  logic        dispAck = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  termio_regs u_termio_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd(busRd), .busWr(busWr),
    .busWdata(busWdata), .busRdata(busRdata), .kbdByte(kbdByte),
    .kbdValid(kbdValid), .dispByte(dispByte), .dispValid(dispValid),
    .dispAck(dispAck), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busRead(input logic [31:0] addr, output logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busRd = 1'b1;
    #1 data = busRdata;
    @(negedge clk);
    busRd = 1'b0; busAddr = '0;
  endtask

  task automatic busWrite(input logic [31:0] addr, input logic [31:0] data);
    @(negedge clk);
    busAddr = addr; busWdata = data; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0; busAddr = '0; busWdata = '0;
  endtask

  task automatic sendKey(input logic [7:0] b);
    @(negedge clk);
    kbdByte = b; kbdValid = 1'b1;
    @(negedge clk);
    kbdValid = 1'b0;
  endtask

  task automatic ackDisplay();
    @(negedge clk);
    dispAck = 1'b1;
    @(negedge clk);
    dispAck = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    busRead(A_RXCTL, d); check("R10 rx ctl after reset", d, 32'h0);
    busRead(A_TXCTL, d); check("R10 tx ctl after reset", d, 32'h1);
    check("R10 dispValid/irq after reset", {dispValid, irq}, 32'h0);
  endtask

  task automatic t_rx_basic();
    logic [31:0] d;
    sendKey(8'hA5);
    busRead(A_RXCTL, d); check("R3 rx ready set", d, 32'h1);
    busRead(A_RXDAT, d); check("R4 rx data zero-extended", d, 32'h0000_00A5);
    busRead(A_RXCTL, d); check("R3 rx ready cleared by read", d, 32'h0);
  endtask

  task automatic t_rx_overwrite();
    logic [31:0] d;
    sendKey(8'h11);
    sendKey(8'h22);
    busRead(A_RXCTL, d); check("R5 ready stays after overwrite", d, 32'h1);
    busRead(A_RXDAT, d); check("R5 newest byte kept", d, 32'h22);
  endtask

  task automatic t_rx_collide();
    logic [31:0] d;
    sendKey(8'h33);
    @(negedge clk);
    busAddr = A_RXDAT; busRd = 1'b1; kbdByte = 8'h44; kbdValid = 1'b1;
    #1 d = busRdata;
    check("R11 collide read returns old byte", d, 32'h33);
    @(negedge clk);
    busRd = 1'b0; kbdValid = 1'b0; busAddr = '0;
    busRead(A_RXCTL, d); check("R11 ready stays on collide", d, 32'h1);
    busRead(A_RXDAT, d); check("R11 new byte stored", d, 32'h44);
  endtask

  task automatic t_tx_flow();
    logic [31:0] d;
    busWrite(A_TXDAT, 32'hDEAD_BE5A);
    #1;
    check("R6 dispByte low byte", {24'h0, dispByte}, 32'h5A);
    check("R6 dispValid high", {31'h0, dispValid}, 32'h1);
    busRead(A_TXCTL, d); check("R6 tx not ready", d, 32'h0);
    repeat (3) @(negedge clk);
    check("R7 held without ack", {23'h0, dispValid, dispByte}, 32'h15A);
    ackDisplay();
    #1;
    check("R7 released after ack", {31'h0, dispValid}, 32'h0);
    busRead(A_TXCTL, d); check("R7 tx ready again", d, 32'h1);
  endtask

  task automatic t_tx_ignored();
    busWrite(A_TXDAT, 32'h61);
    busWrite(A_TXDAT, 32'h62);
    #1;
    check("R8 busy write ignored", {24'h0, dispByte}, 32'h61);
    ackDisplay();
  endtask

  task automatic t_irq();
    logic [31:0] d;
    busWrite(A_RXCTL, 32'hFFFF_FFFE);
    busRead(A_RXCTL, d); check("R2 ie set, ready unchanged", d, 32'h2);
    check("R9 irq low rx not ready", {31'h0, irq}, 32'h0);
    sendKey(8'h7E);
    #1 check("R9 irq rx", {31'h0, irq}, 32'h1);
    busRead(A_RXDAT, d);
    #1 check("R9 irq drops after read", {31'h0, irq}, 32'h0);
    busWrite(A_TXCTL, 32'h2);
    #1 check("R9 irq tx ready", {31'h0, irq}, 32'h1);
    busWrite(A_TXDAT, 32'h41);
    #1 check("R9 irq tx busy", {31'h0, irq}, 32'h0);
    ackDisplay();
    busWrite(A_TXCTL, 32'h1);
    busRead(A_TXCTL, d); check("R2 ie cleared, ready read-only", d, 32'h1);
    #1 check("R9 irq disabled", {31'h0, irq}, 32'h0);
    busWrite(A_RXCTL, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    sendKey(8'h5C);
    busWrite(32'hFFFF_0010, 32'hFFFF_FFFF);
    busWrite(32'h0000_0008, 32'h2);
    #1 check("R1 unmapped write no irq", {31'h0, irq}, 32'h0);
    busRead(32'hFFFF_0010, d); check("R1 unmapped read zero", d, 32'h0);
    busRead(32'hFFFF_0005, d); check("R1 misaligned read zero", d, 32'h0);
    busRead(A_RXCTL, d); check("R1 rx ctl kept", d, 32'h1);
    busRead(A_TXCTL, d); check("R1 tx ctl kept", d, 32'h1);
    busRead(A_RXDAT, d); check("R1 rx data kept", d, 32'h5C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_rx_basic();
    t_rx_overwrite();
    t_rx_collide();
    busWrite(A_RXCTL, 32'h0);
    t_tx_flow();
    t_tx_ignored();
    begin
      logic [31:0] d;
      busRead(A_RXDAT, d);
    end
    t_irq();
    t_unmapped();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule